// File: doc/BRIEF.md
# Inverter Leg Pulse Conditioner

This block takes the single raw PWM level produced by a modulator and turns it into the two gate drives of one inverter leg: a top switch and a bottom switch. Processing runs in a fixed order. A pulse filter first drops every high or low excursion that is too short for the power devices to handle. A dead-band stage then holds both drives off for a programmed interval before either one turns on. A final gate applies an output inhibit and an emergency trip latch.

All intervals are counted in time-base units. One unit is one cycle of the `tick` enable, which an external divider supplies. Both interval codes use an inverted-count encoding, and they are taken in only while reset is held. The trip input is sampled on the master clock. Once the latch is set it can be released only by taking reset low and then high again.

Top module: `pwm_leg_conditioner`

## Requirements
- R1: An excursion of the raw level, high or low, that lasts fewer than the deletion span in time-base units leaves both drives exactly as they were.
- R2: An excursion that lasts at least the deletion span is passed on with its width preserved, and a span equal to the deletion span passes. Before dead-band, the filtered level follows the raw level after a delay of one deletion span.
- R3: The deletion span is 128 minus the 7-bit `del_code`, so code 127 gives 1 and code 0 gives 128. The dead-band span is 64 minus the 6-bit `dly_code`, so code 63 gives 1 and code 0 gives 64. Both spans count `tick` cycles only.
- R4: Each drive turns on one dead-band span after the filtered level changes toward it, and turns off without delay. A passed high pulse of width W therefore gives W minus the dead-band span of top-on time (none if W is not larger), and keeps the bottom drive off for W plus the dead-band span.
- R5: `drv_top` and `drv_bot` are never both high.
- R6: While `inh_n` is low, both drives are low from the next clock on, and filtering continues underneath. When `inh_n` goes high, the drives take the current shaped state at the next clock.
- R7: A high level on `set_trip` drives both drives low and `trip_n` low within two clock edges of the level being applied.
- R8: While `rst_n` is low, both drives and `trip_n` are low. The trip latch clears only at the first clock after `rst_n` rises, and only if `set_trip` is low then. A later low on `set_trip` does not clear it.
- R9: The two codes are captured on clocks while `rst_n` is low. A change to either code while running has no effect on widths or delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset; also captures the codes and releases the trip latch |
| tick | input | 1 | Time-base enable, one unit per high cycle |
| pwm_in | input | 1 | Raw PWM level |
| del_code | input | 7 | Deletion span code, inverted count |
| dly_code | input | 6 | Dead-band span code, inverted count |
| inh_n | input | 1 | Active-low output inhibit |
| set_trip | input | 1 | Emergency trip request, active high |
| drv_top | output | 1 | Top switch drive |
| drv_bot | output | 1 | Bottom switch drive |
| trip_n | output | 1 | Trip status, low when tripped |

## Verification
The bench sends single high pulses on a low background and single low pulses on a high background. It sweeps the pulse width across and past the deletion span for several span pairs, so the counts of on-time and off-time show whether a pulse is deleted, passed or eaten by the dead band. A run with a slower `tick` shows that the spans count units, not clocks. A run with the codes changed mid-operation shows that they are ignored. Separate sequences cover inhibit with resumption, and trip with its release rules. A per-cycle monitor looks for both drives being high at once.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  // inverted-count code: all ones -> 1 unit, all zeros -> 2**bits units
  function automatic logic [15:0] span_of(input logic [15:0] code, input int unsigned bits);
    return (16'd1 << bits) - code;
  endfunction
endpackage

// File: rtl/pwm_pulse_deleter.sv
module pwm_pulse_deleter #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              raw,
  input  logic [CODE_W-1:0] code,
  output logic              lvl
);
  localparam int unsigned CW = CODE_W + 1;

  logic [CW-1:0] span_q;
  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          differ;
  logic          expire;

  always_ff @(posedge clk) begin
    if (!rst_n) span_q <= CW'(pwmc_pkg::span_of(16'(code), CODE_W));
  end

  assign differ = raw != lvl_q;
  assign expire = tick && differ && ((cnt_q + 1'b1) == span_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (expire) begin
      lvl_q <= raw;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl = lvl_q;

  AST_DEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < span_q); // R1
  AST_DEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(raw))); // R2
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              lvl,
  input  logic [CODE_W-1:0] code,
  output logic              top_raw,
  output logic              bot_raw
);
  localparam int unsigned CW = CODE_W + 1;

  logic [CW-1:0] span_q;
  logic [CW-1:0] cnt_q;
  logic          prev_q;
  logic          settled;

  always_ff @(posedge clk) begin
    if (!rst_n) span_q <= CW'(pwmc_pkg::span_of(16'(code), CODE_W));
  end

  assign settled = cnt_q == span_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else if (lvl != prev_q) begin
      prev_q <= lvl;
      cnt_q  <= '0;
    end else if (tick && !settled) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign top_raw = prev_q && settled;
  assign bot_raw = !prev_q && settled;

  AST_DB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= span_q); // R4
  AST_DB_OFF_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl != prev_q) |=> (!top_raw && !bot_raw)); // R4
endmodule

// File: rtl/pwm_trip_gate.sv
module pwm_trip_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic set_trip,
  input  logic inh_n,
  input  logic top_raw,
  input  logic bot_raw,
  output logic drv_top,
  output logic drv_bot,
  output logic trip_n
);
  logic s1_q;
  logic rst_q;
  logic tripped_q;
  logic kill;
  logic top_q;
  logic bot_q;

  always_ff @(posedge clk) s1_q <= set_trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tripped_q <= 1'b1;
    else if (s1_q)   tripped_q <= 1'b1;
    else if (!rst_q) tripped_q <= 1'b0;
  end

  assign kill = tripped_q || s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= 1'b0;
      bot_q <= 1'b0;
    end else begin
      top_q <= top_raw && inh_n && !kill;
      bot_q <= bot_raw && inh_n && !kill;
    end
  end

  assign drv_top = top_q;
  assign drv_bot = bot_q;
  assign trip_n  = !tripped_q;

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_top && drv_bot)); // R5
  AST_TOP_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_top) |-> !$past(drv_bot)); // R4
  AST_BOT_BREAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_bot) |-> !$past(drv_top)); // R4
  AST_INH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !inh_n |=> (!drv_top && !drv_bot)); // R6
  AST_TRIP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    s1_q |=> (!drv_top && !drv_bot && !trip_n)); // R7
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped_q && rst_q) |=> tripped_q); // R8
endmodule

// File: rtl/pwm_leg_conditioner.sv
module pwm_leg_conditioner #(
  parameter int unsigned DEL_W = 7,
  parameter int unsigned DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pwm_in,
  input  logic [DEL_W-1:0] del_code,
  input  logic [DLY_W-1:0] dly_code,
  input  logic             inh_n,
  input  logic             set_trip,
  output logic             drv_top,
  output logic             drv_bot,
  output logic             trip_n
);
  logic filt_lvl;
  logic top_raw;
  logic bot_raw;

  pwm_pulse_deleter #(.CODE_W(DEL_W)) u_del (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(pwm_in),
    .code(del_code), .lvl(filt_lvl)
  );

  pwm_deadband #(.CODE_W(DLY_W)) u_db (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(filt_lvl),
    .code(dly_code), .top_raw(top_raw), .bot_raw(bot_raw)
  );

  pwm_trip_gate u_gate (
    .clk(clk), .rst_n(rst_n), .set_trip(set_trip), .inh_n(inh_n),
    .top_raw(top_raw), .bot_raw(bot_raw),
    .drv_top(drv_top), .drv_bot(drv_bot), .trip_n(trip_n)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!drv_top && !drv_bot)); // R8
endmodule

// File: tb/pwm_leg_conditioner_test.sv
`timescale 1ns/100ps
module pwm_leg_conditioner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       pwm_in = 1'b0;
  logic [6:0] del_code = 7'd0;
  logic [5:0] dly_code = 6'd0;
  logic       inh_n = 1'b1;
  logic       set_trip = 1'b0;
  logic       drv_top, drv_bot, trip_n;

  int errors = 0, checks = 0;
  int top_hi = 0, bot_hi = 0, shoot = 0;
  int tdiv = 1, tphase = 0;
  int cur_pdt = 1, cur_pdy = 1;

  always #2.5 clk = ~clk;

  pwm_leg_conditioner uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in),
    .del_code(del_code), .dly_code(dly_code), .inh_n(inh_n),
    .set_trip(set_trip), .drv_top(drv_top), .drv_bot(drv_bot), .trip_n(trip_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (drv_top) top_hi++;
    if (drv_bot) bot_hi++;
    if (drv_top && drv_bot) shoot++;
    tphase = (tphase + 1) % tdiv;
    tick = (tphase == 0);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_reset(input int pdt, input int pdy, input logic base);
    cur_pdt = pdt; cur_pdy = pdy;
    del_code = 7'(128 - pdt);
    dly_code = 6'(64 - pdy);
    rst_n = 1'b0;
    pwm_in = base;
    cycles(4);
    rst_n = 1'b1;
    cycles(12 + (pdt + pdy) * tdiv * 2);
  endtask

  // one excursion of width w (clock cycles) away from base level
  task automatic pulse(input logic base, input int w, output int t_on, output int b_on, output int win);
    pwm_in = base;
    cycles(4);
    top_hi = 0; bot_hi = 0;
    pwm_in = !base;
    cycles(w);
    pwm_in = base;
    win = w + (w + cur_pdt + cur_pdy) * tdiv + 8;
    cycles(win - w);
    t_on = top_hi; b_on = bot_hi;
  endtask

  task automatic sweep(input int pdt, input int pdy);
    int t_on, b_on, win, pass, on_t;
    do_reset(pdt, pdy, 1'b0);
    for (int w = 1; w <= pdt + 4; w++) begin
      pulse(1'b0, w, t_on, b_on, win);
      pass = (w >= pdt);
      on_t = (pass && w > pdy) ? w - pdy : 0;
      check($sformatf("R1/R2/R4 high pulse w=%0d pdt=%0d pdy=%0d top-on", w, pdt, pdy), t_on, on_t);
      check($sformatf("R1/R2/R4 high pulse w=%0d pdt=%0d pdy=%0d bot-off", w, pdt, pdy), win - b_on, pass ? w + pdy : 0);
    end
    pwm_in = 1'b1;
    cycles(pdt + pdy + 6);
    for (int w = 1; w <= pdt + 4; w++) begin
      pulse(1'b1, w, t_on, b_on, win);
      pass = (w >= pdt);
      on_t = (pass && w > pdy) ? w - pdy : 0;
      check($sformatf("R1/R2/R4 low pulse w=%0d pdt=%0d pdy=%0d bot-on", w, pdt, pdy), b_on, on_t);
      check($sformatf("R1/R2/R4 low pulse w=%0d pdt=%0d pdy=%0d top-off", w, pdt, pdy), win - t_on, pass ? w + pdy : 0);
    end
  endtask

  initial begin
    #500000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t_on, b_on, win;
    // reset state, R8
    cycles(3);
    check("R8 reset drv_top", int'(drv_top), 0);
    check("R8 reset drv_bot", int'(drv_bot), 0);
    check("R8 reset trip_n", int'(trip_n), 0);

    // sweeps with tick every clock, R3 spans from codes
    sweep(4, 2);
    sweep(1, 1);
    sweep(6, 3);
    check("R8 trip_n high after clean reset", int'(trip_n), 1);

    // R9: codes changed while running are ignored (pdt 4, pdy 2 kept)
    do_reset(4, 2, 1'b0);
    del_code = 7'd0;
    dly_code = 6'd0;
    pulse(1'b0, 4, t_on, b_on, win);
    check("R9 code change ignored top-on", t_on, 2);
    check("R9 code change ignored bot-off", win - b_on, 6);
    pulse(1'b0, 3, t_on, b_on, win);
    check("R9 short pulse still deleted", win - b_on, 0);

    // R3: spans count ticks, tick every third clock, pdt 2 units, pdy 1 unit
    tdiv = 3;
    do_reset(2, 1, 1'b0);
    pulse(1'b0, 3, t_on, b_on, win);
    check("R3 slow tick short pulse deleted top", t_on, 0);
    check("R3 slow tick short pulse deleted bot", win - b_on, 0);
    pulse(1'b0, 12, t_on, b_on, win);
    check("R3 slow tick long pulse passes", int'(t_on > 0 && t_on < 12), 1);
    tdiv = 1;

    // R6 inhibit
    do_reset(4, 2, 1'b0);
    check("R6 pre-inhibit bottom on", int'(drv_bot), 1);
    inh_n = 1'b0;
    cyc();
    check("R6 inhibit bottom low", int'(drv_bot), 0);
    top_hi = 0; bot_hi = 0;
    pwm_in = 1'b1;
    cycles(20);
    check("R6 inhibited top never high", top_hi, 0);
    check("R6 inhibited bottom never high", bot_hi, 0);
    inh_n = 1'b1;
    cyc();
    check("R6 release resumes top at once", int'(drv_top), 1);
    check("R6 release bottom stays low", int'(drv_bot), 0);

    // R7 trip within two edges
    set_trip = 1'b1;
    cyc();
    cyc();
    check("R7 trip top low", int'(drv_top), 0);
    check("R7 trip status low", int'(trip_n), 0);
    set_trip = 1'b0;
    pwm_in = 1'b0;
    top_hi = 0; bot_hi = 0;
    cycles(30);
    check("R8 latch holds after set_trip low", int'(trip_n), 0);
    check("R8 outputs stay off while tripped", top_hi + bot_hi, 0);

    // R8 reset release with set_trip high keeps trip
    set_trip = 1'b1;
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    set_trip = 1'b0;
    cycles(5);
    check("R8 release under trip stays tripped", int'(trip_n), 0);
    rst_n = 1'b0;
    cycles(3);
    check("R8 reset holds trip_n low", int'(trip_n), 0);
    rst_n = 1'b1;
    cyc();
    check("R8 clean release clears trip", int'(trip_n), 1);
    cycles(12);
    check("R8 bottom drive returns", int'(drv_bot), 1);

    check("R5 no cycle with both drives high", shoot, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule